// File: doc/BRIEF.md
# Byte/Word Transmit Staging Queue

This block stages outgoing data for a half-duplex serial flash host. Software writes data through one of two ports. The narrow port takes one byte per write. The wide port takes a 32-bit word that carries four bytes. Both ports feed a single queue that holds bytes in order. A downstream serializer takes one byte per accepted request. Each byte it takes counts down a remaining-byte counter, which software loads to set the length of the transfer.

The block reports its free space as a byte count, together with empty and full levels for an interrupt unit. A write that cannot be accepted is not silently dropped. It leaves the queue unchanged and raises a sticky overrun error, which stays set until the next count load. The queue depth is a power-of-two parameter.

Top module: `txq_stage`

## Requirements
- R1: After a synchronous active-low reset the queue is empty. `fifo_empty` is 1, `fifo_full` is 0, `overrun` is 0, `free_bytes` equals DEPTH and `rem_count` is 0.
- R2: A single-byte write enqueues that byte. `free_bytes` is one lower after the clock edge that takes the write.
- R3: A word write with at least four bytes free enqueues four bytes with bits 7:0 first, then 15:8, 23:16 and 31:24. `free_bytes` drops by four after that edge.
- R4: Bytes leave on `pop_data` in exactly the order they were written, across both ports.
- R5: `free_bytes` equals DEPTH minus the bytes held, and is updated on the edge that performs a push or pop. `fifo_full` is 1 exactly when no byte is free. `fifo_empty` is 1 exactly when no byte is held.
- R6: A word write while fewer than four bytes are free enqueues nothing and sets `overrun`.
- R7: A single-byte write into a full queue enqueues nothing and sets `overrun`.
- R8: `overrun` stays at 1 until a cycle with `req_load` high, which clears it, unless a new overrun occurs in that same cycle.
- R9: `pop_ack` is 1 exactly when `pop_req` is high, the queue is not empty and `rem_count` is nonzero. Each acknowledged pop lowers `rem_count` by one.
- R10: `req_load` loads `req_count` into `rem_count`. A load takes precedence over a pop decrement in the same cycle.
- R11: When both write ports fire in the same cycle, the word write is handled as in R3/R6. The byte is not enqueued and `overrun` is set.
- R12: A push and a pop in the same cycle change the held byte count by the pushed amount minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_byte_en | input | 1 | Single-byte write strobe |
| wr_byte_data | input | 8 | Byte to enqueue |
| wr_word_en | input | 1 | Word write strobe |
| wr_word_data | input | 32 | Four bytes to enqueue, low byte first |
| req_load | input | 1 | Load transfer byte count; clears overrun |
| req_count | input | CNT_W | Transfer byte count to load |
| pop_req | input | 1 | Serializer asks for the next byte |
| pop_ack | output | 1 | Byte on pop_data is taken this cycle |
| pop_data | output | 8 | Oldest byte in the queue |
| free_bytes | output | CNT_W | Free space in bytes |
| rem_count | output | CNT_W | Bytes still to move in the transfer |
| fifo_empty | output | 1 | No bytes held |
| fifo_full | output | 1 | No bytes free |
| overrun | output | 1 | Sticky rejected-write error |

## Verification
The bench builds the queue with DEPTH set to 16 and a 16-bit count. With that depth the full level, the one-to-three-bytes-free window that rejects a word, and the pointer wrap-around can all be reached within a few dozen writes. At that size, bytes from word and byte writes interleave across the wrap point. A reference model tracks the bytes held, the remaining count and the overrun flag in every cycle, so that collisions, push with pop, and load with pop are compared against the outputs cycle by cycle.

// File: rtl/txq_pkg.sv
// Shared types for the transmit staging queue.
package txq_pkg;
    // Number of byte lanes in a wide write.
    localparam int LANES = 4;
    // One queued byte.
    typedef logic [7:0] byte_t;
    // Lane vector of a wide write, lane 0 leaves first.
    typedef byte_t [LANES-1:0] lanes_t;
endpackage

// File: rtl/txq_packer.sv
// Turns the two write ports into a lane vector and a push count.
// Assumes: free_cnt is the current free space; both strobes may be high.
// A word has priority; a colliding or non-fitting write is an overflow.
module txq_packer
    import txq_pkg::*;
#(
    parameter int OCC_W = 7
) (
    input  logic             byte_en,
    input  byte_t            byte_data,
    input  logic             word_en,
    input  logic [31:0]      word_data,
    input  logic [OCC_W-1:0] free_cnt,
    output logic [2:0]       push_cnt,
    output lanes_t           lanes,
    output logic             ovf
);
    // Lane steering: word bytes in little-endian order, byte on lane 0.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign lanes[g] = word_en ? word_data[7:0] : byte_data;
        end else begin : g_rest
            assign lanes[g] = word_data[8*g +: 8];
        end
    end

    // Acceptance decision for this cycle's writes.
    always_comb begin
        push_cnt = 3'd0;
        ovf      = 1'b0;
        if (word_en) begin
            if (free_cnt >= OCC_W'(LANES)) push_cnt = 3'(LANES);
            else                           ovf = 1'b1;
            if (byte_en)                   ovf = 1'b1;
        end else if (byte_en) begin
            if (free_cnt != '0) push_cnt = 3'd1;
            else                ovf = 1'b1;
        end
    end
endmodule

// File: rtl/txq_store.sv
// Byte storage ring with a multi-byte write side and a single-byte read side.
// Assumes: DEPTH is a power of two, at least 4; push_cnt never exceeds free space.
module txq_store
    import txq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       push_cnt,
    input  lanes_t           lanes,
    input  logic             pop,
    output byte_t            head,
    output logic [OCC_W-1:0] occ
);
    byte_t             mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // Byte array write: lane k lands k places after the write pointer.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(push_cnt)) mem[wr_ptr + PTR_W'(k)] <= lanes[k];
        end
    end

    // Pointer and occupancy bookkeeping for push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_cnt);
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            occ <= occ + OCC_W'(push_cnt) - OCC_W'(pop);
        end
    end

    assign head = mem[rd_ptr];

    // The packer must never push more than the free space.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        OCC_W'(push_cnt) <= OCC_W'(DEPTH) - occ);

    // Occupancy never exceeds the depth.
    assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));
endmodule

// File: rtl/txq_reqcnt.sv
// Remaining-byte counter of the current transfer.
// Assumes: dec only when the count is nonzero; load wins over dec.
module txq_reqcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] rem
);
    // Load or count down by one per taken byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     rem <= '0;
        else if (load)  rem <= load_val;
        else if (dec)   rem <= rem - 1'b1;
    end

    // A load takes effect regardless of a same-cycle pop.
    assert_load_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rem == $past(load_val));

    // A pop without load lowers the count by exactly one.
    assert_dec_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> rem == $past(rem) - 1'b1);
endmodule

// File: rtl/txq_stage.sv
// Transmit staging queue with a byte port and a word port.
// Assumes: DEPTH is a power of two, at least 4, and fits in CNT_W bits.
// Reports free space in bytes, empty and full levels, and a sticky overrun.
module txq_stage
    import txq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_byte_en,
    input  logic [7:0]       wr_byte_data,
    input  logic             wr_word_en,
    input  logic [31:0]      wr_word_data,
    input  logic             req_load,
    input  logic [CNT_W-1:0] req_count,
    input  logic             pop_req,
    output logic             pop_ack,
    output logic [7:0]       pop_data,
    output logic [CNT_W-1:0] free_bytes,
    output logic [CNT_W-1:0] rem_count,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             overrun
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = PTR_W + 1;

    logic [OCC_W-1:0] occ;
    logic [OCC_W-1:0] free_int;
    logic [2:0]       push_cnt;
    lanes_t           lanes;
    logic             ovf;
    logic             ovr_q;

    assign free_int   = OCC_W'(DEPTH) - occ;
    assign fifo_empty = (occ == '0);
    assign fifo_full  = (free_int == '0);
    assign free_bytes = CNT_W'(free_int);
    assign pop_ack    = pop_req && !fifo_empty && (rem_count != '0);
    assign overrun    = ovr_q;

    txq_packer #(.OCC_W(OCC_W)) u_packer (
        .byte_en   (wr_byte_en),
        .byte_data (wr_byte_data),
        .word_en   (wr_word_en),
        .word_data (wr_word_data),
        .free_cnt  (free_int),
        .push_cnt  (push_cnt),
        .lanes     (lanes),
        .ovf       (ovf)
    );

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_cnt (push_cnt),
        .lanes    (lanes),
        .pop      (pop_ack),
        .head     (pop_data),
        .occ      (occ)
    );

    txq_reqcnt #(.CNT_W(CNT_W)) u_reqcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (req_load),
        .load_val (req_count),
        .dec      (pop_ack),
        .rem      (rem_count)
    );

    // Sticky error: a new overflow sets it, a count load clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovf | (ovr_q & ~req_load);
    end

    // A word that does not fit raises the error on the next cycle.
    assert_word_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word_en && free_bytes < CNT_W'(4)) |=> overrun);

    // A byte written into a full queue raises the error.
    assert_byte_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_en && fifo_full) |=> overrun);

    // The error holds until a load.
    assert_ovr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !req_load) |=> overrun);

    // A full queue with no pop stays full.
    assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !pop_ack) |=> fifo_full);

    // Colliding writes never enqueue the byte beside a word.
    assert_collide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word_en && wr_byte_en) |=> overrun);
endmodule

// File: tb/txq_stage_tb.sv
// Scoreboard bench: the driver task queues expected bytes, the monitor
// compares popped bytes; a cycle model checks the flags and counters.
module txq_stage_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_byte_en = 1'b0;
    logic [7:0]       wr_byte_data = '0;
    logic             wr_word_en = 1'b0;
    logic [31:0]      wr_word_data = '0;
    logic             req_load = 1'b0;
    logic [CNT_W-1:0] req_count = '0;
    logic             pop_req = 1'b0;
    logic             pop_ack;
    logic [7:0]       pop_data;
    logic [CNT_W-1:0] free_bytes;
    logic [CNT_W-1:0] rem_count;
    logic             fifo_empty;
    logic             fifo_full;
    logic             overrun;

    txq_stage #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
        .wr_word_en(wr_word_en), .wr_word_data(wr_word_data),
        .req_load(req_load), .req_count(req_count),
        .pop_req(pop_req), .pop_ack(pop_ack), .pop_data(pop_data),
        .free_bytes(free_bytes), .rem_count(rem_count),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] exp_q [$];
    logic [7:0] mon_exp;
    int    n_vec = 0;
    int    n_bad = 0;
    string cur_tag = "R4";
    int    m_occ = 0;
    int    m_rem = 0;
    bit    m_ovr = 1'b0;

    task automatic chk(string tag, string what, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: every taken byte must match the oldest expected byte (R4).
    always @(negedge clk) begin
        if (rst_n && pop_ack) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s pop_data actual=%0h expected=none", cur_tag, pop_data);
            end else begin
                mon_exp = exp_q.pop_front();
                if (pop_data !== mon_exp) begin
                    n_bad++;
                    $display("FAIL %s pop_data actual=%0h expected=%0h", cur_tag, pop_data, mon_exp);
                end
            end
        end
    end

    // Driver: apply one cycle of stimulus, update the model, check outputs.
    task automatic cyc(bit be, logic [7:0] bd, bit we, logic [31:0] wd,
                       bit pr, bit ld, int cnt, string tag);
        bit ack;
        bit ovf;
        int np;
        cur_tag      = tag;
        wr_byte_en   = be;
        wr_byte_data = bd;
        wr_word_en   = we;
        wr_word_data = wd;
        pop_req      = pr;
        req_load     = ld;
        req_count    = cnt[CNT_W-1:0];
        ack = pr && (m_occ > 0) && (m_rem > 0);
        @(negedge clk);
        chk(tag, "pop_ack", pop_ack, ack);
        np  = 0;
        ovf = 1'b0;
        if (we) begin
            if (DEPTH - m_occ >= 4) begin
                for (int i = 0; i < 4; i++) exp_q.push_back(wd[8*i +: 8]);
                np = 4;
            end else ovf = 1'b1;
            if (be) ovf = 1'b1;
        end else if (be) begin
            if (m_occ < DEPTH) begin
                exp_q.push_back(bd);
                np = 1;
            end else ovf = 1'b1;
        end
        m_occ = m_occ + np - (ack ? 1 : 0);
        m_rem = ld ? cnt : m_rem - (ack ? 1 : 0);
        m_ovr = ovf | (m_ovr & !ld);
        @(posedge clk);
        #1;
        wr_byte_en = 1'b0;
        wr_word_en = 1'b0;
        pop_req    = 1'b0;
        req_load   = 1'b0;
        chk(tag, "free_bytes", free_bytes, DEPTH - m_occ);
        chk(tag, "fifo_empty", fifo_empty, m_occ == 0);
        chk(tag, "fifo_full",  fifo_full,  m_occ == DEPTH);
        chk(tag, "overrun",    overrun,    m_ovr);
        chk(tag, "rem_count",  rem_count,  m_rem);
    endtask

    task automatic pops(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 32'h0, 1, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "fifo_empty", fifo_empty, 1);
        chk("R1", "fifo_full",  fifo_full,  0);
        chk("R1", "overrun",    overrun,    0);
        chk("R1", "free_bytes", free_bytes, DEPTH);
        chk("R1", "rem_count",  rem_count,  0);

        cyc(1, 8'h11, 0, 32'h0, 0, 0, 0, "R2");           // single byte
        cyc(0, 8'h00, 1, 32'h55443322, 0, 0, 0, "R3");    // word, low byte first
        cyc(0, 8'h00, 0, 32'h0, 0, 1, 5, "R10");          // load count 5
        pops(5, "R4");                                    // order across ports
        cyc(0, 8'h00, 0, 32'h0, 1, 0, 0, "R9");           // count zero, empty
        cyc(0, 8'h00, 0, 32'h0, 0, 1, 3, "R10");
        cyc(0, 8'h00, 0, 32'h0, 1, 0, 0, "R9");           // empty, count nonzero

        for (int i = 0; i < 3; i++)
            cyc(0, 8'h00, 1, 32'hA3A2A1A0 + i * 32'h04040404, 0, 0, 0, "R3");
        for (int i = 0; i < 3; i++)
            cyc(1, 8'hB0 + 8'(i), 0, 32'h0, 0, 0, 0, "R5");
        cyc(0, 8'h00, 1, 32'hDEADBEEF, 0, 0, 0, "R6");    // one byte free
        cyc(0, 8'h00, 0, 32'h0, 0, 0, 0, "R8");           // sticky
        cyc(1, 8'hC0, 0, 32'h0, 0, 0, 0, "R5");           // reaches full
        cyc(1, 8'hC1, 0, 32'h0, 0, 0, 0, "R7");           // into full
        cyc(0, 8'h00, 0, 32'h0, 0, 1, 20, "R8");          // load clears
        pops(6, "R4");
        cyc(1, 8'hE0, 1, 32'hD3D2D1D0, 0, 0, 0, "R11");   // collision
        cyc(1, 8'hE1, 0, 32'h0, 1, 0, 0, "R12");          // push with pop
        cyc(0, 8'h00, 1, 32'hF3F2F1F0, 1, 0, 0, "R6");    // two free, pop too
        cyc(0, 8'h00, 0, 32'h0, 1, 1, 7, "R10");          // load wins over pop
        pops(7, "R9");
        cyc(0, 8'h00, 0, 32'h0, 1, 0, 0, "R9");           // count exhausted
        cyc(0, 8'h00, 0, 32'h0, 0, 1, 10, "R8");
        pops(m_occ, "R4");
        cyc(0, 8'h00, 0, 32'h0, 1, 0, 0, "R9");           // drained
        chk("R4", "queue drained", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule